// File: doc/BRIEF.md
# Serial Debug Bridge to Memory-Mapped Bus

This block lets an external host reach a memory-mapped bus over a two-wire serial link. It receives 8N1 bytes on a receive pin and groups them into short command packets. Each packet becomes exactly one 32-bit bus transaction, driven through a master port with a cyc/stb/we/ack handshake. For a read, the word returned by the bus is sent back to the host as four framed bytes on the transmit pin.

A select input decides which side owns the serial pins. When it is high, the bridge owns them. When it is low, the pins pass straight through to the system UART, and the bridge receive path sees a constant idle-high line. The bit period is a whole number of clock cycles, set by `CLKS_PER_BIT`.

Internally the data moves as streams. The receiver offers each byte as a one-cycle valid pulse with no back-pressure; bytes that arrive while a bus cycle or a response is in progress are dropped. The response serializer takes a byte only when the transmitter raises ready, and the engine holds the byte steady until that happens. On the bus side, the slave's ack is the only back-pressure, and the master waits on it for as long as it takes.

Top module: `dbg_uart_bridge`

## Requirements
- R1: Received bytes use 8N1 framing: a low start bit, eight data bits least-significant first, and a high stop bit, on a line that idles high. Back-to-back frames and frames separated by extra idle bit-times are both accepted. Each bit lasts `CLKS_PER_BIT` clock cycles and is sampled near its middle.
- R2: A write packet is a byte 0x01, a size byte, four address bytes and four data bytes. Address and data are sent most-significant byte first. It produces one bus cycle with `bus_we_o`=1 carrying that address and that data.
- R3: A read packet is a byte 0x02, a size byte and four address bytes. It produces one bus cycle with `bus_we_o`=0. The word captured on ack is then sent on `ser_tx_o` as four 8N1 bytes, bits 31:24 first. The transmit line stays high while the bus cycle is open.
- R4: During a bus cycle, `bus_cyc_o` and `bus_stb_o` are both high and all bits of `bus_sel_o` are 1. Address, write-enable and write data stay stable until `bus_ack_i` is seen.
- R5: A byte other than 0x01 or 0x02 that arrives while the bridge waits for a command is discarded and starts no bus cycle. A valid packet that follows is executed normally.
- R6: The size byte's value is ignored. Every packet moves exactly one word, and `bus_stb_o` falls in the cycle after the ack.
- R7: With `sel_dbg`=0, `ser_tx_o` follows `sys_tx_i`, `sys_rx_o` follows `ser_rx_i`, and packets on `ser_rx_i` start no bus cycle. With `sel_dbg`=1, `sys_rx_o` is held high and `ser_tx_o` carries the bridge's transmitter.
- R8: A synchronous reset drops any packet in progress, returns the parser to waiting for a command, closes any bus cycle and drives the bridge's transmit line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_dbg | input | 1 | 1: bridge owns the serial pins; 0: system UART owns them |
| ser_rx_i | input | 1 | Serial receive pin |
| ser_tx_o | output | 1 | Serial transmit pin |
| sys_rx_o | output | 1 | Receive line forwarded to the system UART |
| sys_tx_i | input | 1 | Transmit line from the system UART |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_stb_o | output | 1 | Bus strobe |
| bus_we_o | output | 1 | Bus write enable |
| bus_adr_o | output | ADDR_W | Bus address |
| bus_dat_o | output | DATA_W | Bus write data |
| bus_sel_o | output | DATA_W/8 | Byte selects, all active |
| bus_dat_i | input | DATA_W | Bus read data |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
Most internal faults become visible on the bus port within one packet time. If the parser state or the byte index is wrong, the bus cycle carries a shifted or rotated address or data word, or no cycle starts at all, and this shows in the cycle that follows the last byte's stop-bit midpoint. Faults in the receiver's bit counter or sample point corrupt every byte. Faults in the response path show only on reads: the returned word comes back with its bytes in the wrong order, its bits reversed, or a stop bit missing. The bench therefore pairs every write with a read-back of the same address, so the four returned bytes expose any mismatch within about forty bit-times.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

  typedef enum logic [2:0] {
    PK_OPCODE, PK_SIZE, PK_ADDR, PK_WDATA, PK_BUS, PK_REPLY
  } pk_state_t;
endpackage

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx #(
  parameter int CLKS_PER_BIT = 1042,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o
);
  import dbg_bridge_pkg::*;

  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  rx_state_t              st;
  logic [CW-1:0]          cnt;
  logic [2:0]             bitn;
  logic [7:0]             shreg;

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= RX_IDLE;
      cnt          <= '0;
      bitn         <= '0;
      shreg        <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!line_s) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt   <= '0;
            shreg <= {line_s, shreg[7:1]};
            if (bitn == 3'd7) st <= RX_STOP;
            bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (line_s) begin
              byte_valid_o <= 1'b1;
              byte_data_o  <= shreg;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_serial_tx.sv
module dbg_serial_tx #(
  parameter int CLKS_PER_BIT = 1042
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  output logic       line_o
);
  localparam int CW     = $clog2(CLKS_PER_BIT);
  localparam int FRAMEB = 10;

  logic              busy;
  logic [FRAMEB-1:0] frame;
  logic [CW-1:0]     cnt;
  logic [3:0]        bitn;

  assign in_ready_o = !busy;
  assign line_o     = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      frame <= '1;
      cnt   <= '0;
      bitn  <= '0;
    end else if (!busy) begin
      if (in_valid_i) begin
        frame <= {1'b1, in_data_i, 1'b0};
        busy  <= 1'b1;
        cnt   <= '0;
        bitn  <= '0;
      end
    end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
      cnt <= '0;
      if (bitn == 4'(FRAMEB - 1)) begin
        busy <= 1'b0;
      end else begin
        frame <= {1'b1, frame[FRAMEB-1:1]};
        bitn  <= bitn + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic [7:0]          tx_data_o,
  output logic                bus_cyc_o,
  output logic                bus_stb_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_adr_o,
  output logic [DATA_W-1:0]   bus_dat_o,
  output logic [DATA_W/8-1:0] bus_sel_o,
  input  logic [DATA_W-1:0]   bus_dat_i,
  input  logic                bus_ack_i
);
  import dbg_bridge_pkg::*;

  localparam int NA = ADDR_W / 8;
  localparam int ND = DATA_W / 8;
  localparam int IW = $clog2((NA > ND) ? NA : ND);

  pk_state_t           st;
  logic [IW-1:0]       idx;
  logic                is_read;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;

  assign bus_cyc_o  = (st == PK_BUS);
  assign bus_stb_o  = (st == PK_BUS);
  assign bus_we_o   = !is_read;
  assign bus_adr_o  = addr_q;
  assign bus_dat_o  = wdata_q;
  assign bus_sel_o  = '1;
  assign tx_valid_o = (st == PK_REPLY);
  assign tx_data_o  = rdata_q[DATA_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PK_OPCODE;
      idx     <= '0;
      is_read <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        PK_OPCODE: if (rx_valid_i) begin
          if (rx_data_i == OP_WRITE) begin
            is_read <= 1'b0;
            st      <= PK_SIZE;
          end else if (rx_data_i == OP_READ) begin
            is_read <= 1'b1;
            st      <= PK_SIZE;
          end
        end
        PK_SIZE: if (rx_valid_i) begin
          idx <= '0;
          st  <= PK_ADDR;
        end
        PK_ADDR: if (rx_valid_i) begin
          addr_q <= {addr_q[ADDR_W-9:0], rx_data_i};
          if (idx == IW'(NA - 1)) begin
            idx <= '0;
            st  <= is_read ? PK_BUS : PK_WDATA;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PK_WDATA: if (rx_valid_i) begin
          wdata_q <= {wdata_q[DATA_W-9:0], rx_data_i};
          if (idx == IW'(ND - 1)) begin
            idx <= '0;
            st  <= PK_BUS;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PK_BUS: if (bus_ack_i) begin
          if (is_read) begin
            rdata_q <= bus_dat_i;
            idx     <= '0;
            st      <= PK_REPLY;
          end else begin
            st <= PK_OPCODE;
          end
        end
        default: if (tx_ready_i) begin
          rdata_q <= rdata_q << 8;
          if (idx == IW'(ND - 1)) st <= PK_OPCODE;
          idx <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_uart_bridge.sv
module dbg_uart_bridge #(
  parameter int CLKS_PER_BIT = 1042,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_dbg,
  input  logic                ser_rx_i,
  output logic                ser_tx_o,
  output logic                sys_rx_o,
  input  logic                sys_tx_i,
  output logic                bus_cyc_o,
  output logic                bus_stb_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_adr_o,
  output logic [DATA_W-1:0]   bus_dat_o,
  output logic [DATA_W/8-1:0] bus_sel_o,
  input  logic [DATA_W-1:0]   bus_dat_i,
  input  logic                bus_ack_i
);
  logic       br_rx, br_tx;
  logic       rxb_valid;
  logic [7:0] rxb_data;
  logic       txb_valid, txb_ready;
  logic [7:0] txb_data;

  assign br_rx    = sel_dbg ? ser_rx_i : 1'b1;
  assign sys_rx_o = sel_dbg ? 1'b1 : ser_rx_i;
  assign ser_tx_o = sel_dbg ? br_tx : sys_tx_i;

  dbg_serial_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .line_i(br_rx),
    .byte_valid_o(rxb_valid), .byte_data_o(rxb_data)
  );

  dbg_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst),
    .rx_valid_i(rxb_valid), .rx_data_i(rxb_data),
    .tx_valid_o(txb_valid), .tx_ready_i(txb_ready), .tx_data_o(txb_data),
    .bus_cyc_o(bus_cyc_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
    .bus_adr_o(bus_adr_o), .bus_dat_o(bus_dat_o), .bus_sel_o(bus_sel_o),
    .bus_dat_i(bus_dat_i), .bus_ack_i(bus_ack_i)
  );

  dbg_serial_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst(rst),
    .in_valid_i(txb_valid), .in_ready_o(txb_ready), .in_data_i(txb_data),
    .line_o(br_tx)
  );
endmodule

// File: rtl/dbg_uart_bridge_chk.sv
module dbg_uart_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                sel_dbg,
  input logic                ser_tx_o,
  input logic                bus_cyc_o,
  input logic                bus_stb_o,
  input logic                bus_we_o,
  input logic [ADDR_W-1:0]   bus_adr_o,
  input logic [DATA_W-1:0]   bus_dat_o,
  input logic [DATA_W/8-1:0] bus_sel_o,
  input logic                bus_ack_i
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_cyc_o && (ser_tx_o || !sel_dbg))); // R8

  AST_STB_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_stb_o && !bus_ack_i) |=> (bus_stb_o && $stable(bus_adr_o)
      && $stable(bus_we_o) && $stable(bus_dat_o))); // R4

  AST_STB_FRAME: assert property (@(posedge clk) disable iff (rst)
    bus_stb_o |-> (bus_cyc_o && bus_sel_o == '1)); // R4

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (bus_stb_o && bus_ack_i) |=> !bus_stb_o); // R6

  AST_TX_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    (sel_dbg && bus_cyc_o) |-> ser_tx_o); // R3
endmodule

bind dbg_uart_bridge dbg_uart_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_dbg(sel_dbg), .ser_tx_o(ser_tx_o),
  .bus_cyc_o(bus_cyc_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
  .bus_adr_o(bus_adr_o), .bus_dat_o(bus_dat_o), .bus_sel_o(bus_sel_o),
  .bus_ack_i(bus_ack_i)
);

// File: tb/dbg_uart_bridge_test.sv
module dbg_uart_bridge_test;
  localparam int CPB  = 8;
  localparam int HALF = CPB / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_dbg = 1'b1;
  logic        ser_rx_i = 1'b1;
  logic        ser_tx_o, sys_rx_o;
  logic        sys_tx_i = 1'b1;
  logic        bus_cyc_o, bus_stb_o, bus_we_o;
  logic [31:0] bus_adr_o, bus_dat_o, bus_dat_i;
  logic [3:0]  bus_sel_o;
  logic        bus_ack_i = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_uart_bridge #(.CLKS_PER_BIT(CPB)) uut (
    .clk(clk), .rst(rst), .sel_dbg(sel_dbg), .ser_rx_i(ser_rx_i),
    .ser_tx_o(ser_tx_o), .sys_rx_o(sys_rx_o), .sys_tx_i(sys_tx_i),
    .bus_cyc_o(bus_cyc_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
    .bus_adr_o(bus_adr_o), .bus_dat_o(bus_dat_o), .bus_sel_o(bus_sel_o),
    .bus_dat_i(bus_dat_i), .bus_ack_i(bus_ack_i)
  );

  // slave model: 16 words, programmable ack latency
  logic [31:0] mem [16];
  int ack_lat = 0;
  int wait_cnt = 0;
  int txn_cnt = 0;
  int viol = 0;
  bit prev_done = 0;
  logic        last_we;
  logic [31:0] last_adr, last_dat;

  assign bus_dat_i = mem[bus_adr_o[5:2]];

  always @(posedge clk) begin
    bus_ack_i <= 1'b0;
    if (rst) begin
      wait_cnt <= 0;
    end else if (bus_stb_o && !bus_ack_i) begin
      if (wait_cnt == ack_lat) begin
        bus_ack_i <= 1'b1;
        wait_cnt  <= 0;
        if (bus_we_o) mem[bus_adr_o[5:2]] <= bus_dat_o;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    prev_done <= bus_stb_o && bus_ack_i;
    if (!rst) begin
      if (bus_stb_o && (!bus_cyc_o || bus_sel_o != 4'hF)) viol <= viol + 1;
      if (prev_done && bus_stb_o) viol <= viol + 1;
      if (bus_stb_o && bus_ack_i) begin
        txn_cnt  <= txn_cnt + 1;
        last_we  <= bus_we_o;
        last_adr <= bus_adr_o;
        last_dat <= bus_dat_o;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk) ser_rx_i = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx_i = b[i];
      repeat (CPB) @(negedge clk);
    end
    ser_rx_i = 1'b1;
    repeat (CPB * (1 + gap)) @(negedge clk);
  endtask

  task automatic send_write(input logic [7:0] size, input logic [31:0] a,
                            input logic [31:0] d, input int gap);
    send_byte(8'h01, gap);
    send_byte(size, gap);
    for (int i = 3; i >= 0; i--) send_byte(a[8*i +: 8], gap);
    for (int i = 3; i >= 0; i--) send_byte(d[8*i +: 8], gap);
    repeat (3 * CPB) @(negedge clk);
  endtask

  task automatic send_read_hdr(input logic [31:0] a, input int gap);
    send_byte(8'h02, gap);
    send_byte(8'h01, gap);
    for (int i = 3; i >= 0; i--) send_byte(a[8*i +: 8], gap);
  endtask

  task automatic recv_word(output logic [31:0] w, output int bad_stop);
    logic [7:0] b;
    w = '0;
    bad_stop = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      while (ser_tx_o !== 1'b0) @(negedge clk);
      repeat (HALF) @(negedge clk);
      if (ser_tx_o !== 1'b0) bad_stop++;
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        b[i] = ser_tx_o;
      end
      repeat (CPB) @(negedge clk);
      if (ser_tx_o !== 1'b1) bad_stop++;
      w = {w[23:0], b};
    end
  endtask

  task automatic do_read(input logic [31:0] a, input int gap, output logic [31:0] w,
                         output int bad);
    logic [31:0] rw;
    int bs;
    fork
      send_read_hdr(a, gap);
      recv_word(rw, bs);
    join
    w = rw;
    bad = bs;
    repeat (2 * CPB) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired, R1 R2 R3 stalled, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, a, d;
    int bad, n0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 tx idle high after reset", {31'b0, ser_tx_o}, 32'd1);
    chk("R8 no bus cycle after reset", {31'b0, bus_cyc_o}, 32'd0);
    chk("R7 sys_rx held high when bridge selected", {31'b0, sys_rx_o}, 32'd1);

    // R1 R2 R3: write then read back, sweeping addresses, data, gaps, ack latency
    for (int i = 0; i < 8; i++) begin
      a = 32'h0000_0400 + 32'(i * 4);
      d = (i == 0) ? 32'hFFFF_FFFF : (32'(i) * 32'h1357_9BDF) ^ (32'(i) << 28);
      ack_lat = i % 4;
      n0 = txn_cnt;
      send_write(8'h01, a, d, i % 3);
      chk("R2 one bus write per packet", 32'(txn_cnt - n0), 32'd1);
      chk("R2 write enable", {31'b0, last_we}, 32'd1);
      chk("R2 write address MSB first", last_adr, a);
      chk("R2 R1 write data MSB first LSB-first bits", last_dat, d);
      do_read(a, (i + 1) % 3, w, bad);
      chk("R3 R1 read-back word", w, d);
      chk("R3 response stop/start bits", 32'(bad), 32'd0);
      chk("R3 read enable low", {31'b0, last_we}, 32'd0);
    end
    chk("R4 R6 bus handshake violations", 32'(viol), 32'd0);

    // R6: odd size byte still moves exactly one word
    n0 = txn_cnt;
    send_write(8'h07, 32'h0000_0438, 32'h0102_0304, 0);
    chk("R6 size ignored single write", 32'(txn_cnt - n0), 32'd1);
    chk("R6 size ignored data", last_dat, 32'h0102_0304);

    // R5: bogus command bytes are dropped
    n0 = txn_cnt;
    send_byte(8'h55, 1);
    send_byte(8'h00, 1);
    send_byte(8'h03, 1);
    send_byte(8'hFF, 1);
    repeat (4 * CPB) @(negedge clk);
    chk("R5 unknown opcodes start no cycle", 32'(txn_cnt - n0), 32'd0);
    chk("R5 tx quiet after unknown opcodes", {31'b0, ser_tx_o}, 32'd1);
    send_write(8'h01, 32'h0000_043C, 32'hCAFE_0001, 0);
    chk("R5 next valid packet executed", 32'(txn_cnt - n0), 32'd1);
    chk("R5 next valid packet address", last_adr, 32'h0000_043C);

    // R7: pass-through when bridge not selected
    @(negedge clk) sel_dbg = 1'b0;
    ser_rx_i = 1'b0; sys_tx_i = 1'b0;
    @(negedge clk);
    chk("R7 sys_rx follows ser_rx low", {31'b0, sys_rx_o}, 32'd0);
    chk("R7 ser_tx follows sys_tx low", {31'b0, ser_tx_o}, 32'd0);
    ser_rx_i = 1'b1; sys_tx_i = 1'b1;
    @(negedge clk);
    chk("R7 sys_rx follows ser_rx high", {31'b0, sys_rx_o}, 32'd1);
    chk("R7 ser_tx follows sys_tx high", {31'b0, ser_tx_o}, 32'd1);
    n0 = txn_cnt;
    send_write(8'h01, 32'h0000_0400, 32'h1111_2222, 0);
    chk("R7 deselected packet ignored", 32'(txn_cnt - n0), 32'd0);
    @(negedge clk) sel_dbg = 1'b1;
    sys_tx_i = 1'b0;
    @(negedge clk);
    chk("R7 selected ser_tx ignores sys_tx", {31'b0, ser_tx_o}, 32'd1);
    sys_tx_i = 1'b1;
    do_read(32'h0000_0400, 0, w, bad);
    chk("R7 deselected packet left memory untouched", w, 32'hFFFF_FFFF);

    // R8: reset in the middle of a packet
    send_byte(8'h01, 0);
    send_byte(8'h01, 0);
    send_byte(8'h00, 0);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 tx high after mid-packet reset", {31'b0, ser_tx_o}, 32'd1);
    n0 = txn_cnt;
    send_write(8'h01, 32'h0000_0410, 32'h5A5A_A5A5, 1);
    chk("R8 parser restarted at opcode", last_adr, 32'h0000_0410);
    chk("R8 single write after reset", 32'(txn_cnt - n0), 32'd1);
    chk("R4 R6 bus handshake violations final", 32'(viol), 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule